// File: doc/BRIEF.md
# Multi-Entry Ternary Flow Classifier

This block sorts packets into flows. Each lookup presents a 112-bit header key, already extracted, with a strobe that marks the start of a packet. The key is compared in parallel against four ternary match entries. Each entry stores a compare value, a per-bit care mask and a 16-bit flow identifier. One clock later the block reports the full match vector, the flow identifier chosen by priority, a no-match flag and a 16-bit hash folded from the key. All of these are valid in the same cycle as the registered start-of-packet flag.

A control-packet decoder updates the entries through a programming port. A command names a base entry, a number of entries and a transmit-enable bit. The data beats that follow rewrite consecutive entries, starting at the base. The transmit-enable bit is kept in a register and driven out to the queue manager. A value of 0 stops all output transmission downstream.

Key layout, most significant bits first: source address in [111:80], destination address in [79:48], source port in [47:32], destination port in [31:16], protocol byte in [15:8], and zero padding in [7:0]. Stored values and masks use the same positions.

Top module: `flow_classifier`

## Requirements
- R1: An entry hits only when its enable bit is 1 and every key bit whose mask bit is 1 equals the stored value bit. Key bits whose mask bit is 0 are ignored. A single differing cared-for bit prevents the hit.
- R2: Bit i of `res_match` is the hit of entry i. `res_flow_id` carries the identifier of the lowest-numbered entry that hits.
- R3: When no entry hits, `res_no_match` is 1, `res_match` is 0 and `res_flow_id` is 0.
- R4: `res_hash` is the XOR of the seven 16-bit slices key[16k+15:16k], for k = 0 to 6.
- R5: A lookup presented with `key_valid` produces `res_valid` = 1 exactly one clock later. In that same cycle `res_sop` equals the `key_sop` of the lookup, and the flow identifier and hash belong to that lookup. Without `key_valid`, `res_valid` is 0.
- R6: A `cmd_valid` cycle loads a base index and a count. Each later `wr_valid` beat writes value, mask, flow identifier and enable bit into entry base, then base+1, and so on, one entry per beat.
- R7: A beat is ignored in each of these cases: the command's count is used up, the count was 0, the target index is past entry 3 (no wrap to 0), or the beat arrives in the same cycle as `cmd_valid`.
- R8: `tx_enable` takes `cmd_tx_en` one clock after each `cmd_valid`. Between commands it holds its value.
- R9: After reset, every entry is disabled, `res_valid` is 0 and `tx_enable` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_valid | input | 1 | Lookup request |
| key_sop | input | 1 | Lookup key belongs to a start-of-packet word |
| key_data | input | 112 | Header key |
| cmd_valid | input | 1 | Programming command strobe |
| cmd_base | input | 2 | First entry to rewrite |
| cmd_count | input | 3 | Number of entries to rewrite |
| cmd_tx_en | input | 1 | Transmit-enable value carried by the command |
| wr_valid | input | 1 | Entry data beat strobe |
| wr_value | input | 112 | Compare value for the entry |
| wr_mask | input | 112 | Care mask, 1 = compare this bit |
| wr_flow_id | input | 16 | Flow identifier for the entry |
| wr_enable | input | 1 | Entry enable bit |
| res_valid | output | 1 | Lookup result valid |
| res_sop | output | 1 | Start-of-packet flag of the result |
| res_match | output | 4 | Per-entry hit vector |
| res_no_match | output | 1 | No entry hit |
| res_flow_id | output | 16 | Priority-selected flow identifier |
| res_hash | output | 16 | Folded key hash |
| tx_enable | output | 1 | Transmit enable to queue manager |

## Verification
Entries that care about disjoint fields (source address only, destination address only, protocol only) are probed with keys that hit one, several or none of them. This separates a correct per-field mask from a compare that ignores the mask, and lowest-index priority from highest-index priority. A key that differs from a stored value in a single cared-for bit shows whether the masked compare covers every bit. A wildcard entry, a disabled entry, surplus beats, a wrapping range, a zero count and a command colliding with a beat each leave a different trace in the hit vector and flow identifier. That trace shows whether the range sequencer wrote the intended entries and only those.

// File: rtl/fc_pkg.sv
// Package: shared defaults for the flow classifier.
// Assumes: key layout is fixed at 112 bits; identifiers and hash are 16 bits.
package fc_pkg;
    localparam int FC_KEY_W   = 112;
    localparam int FC_FID_W   = 16;
    localparam int FC_HASH_W  = 16;
    localparam int FC_ENTRIES = 4;

    // Number of slices of width w needed to cover n bits.
    function automatic int fc_slices(input int n, input int w);
        return (n + w - 1) / w;
    endfunction
endpackage

// File: rtl/fc_cam_entry.sv
// Module: one ternary match entry with storage and compare.
// What it does: holds value, care mask, flow id and enable; reports a hit
// when all cared-for key bits equal the stored value.
// Assumes: writes take effect on the clock edge, so a lookup in the write
// cycle still sees the old contents.
module fc_cam_entry #(
    parameter int KEY_W = fc_pkg::FC_KEY_W,
    parameter int FID_W = fc_pkg::FC_FID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_value,
    input  logic [KEY_W-1:0] wr_mask,
    input  logic [FID_W-1:0] wr_fid,
    input  logic             wr_live,
    input  logic [KEY_W-1:0] key,
    output logic             hit,
    output logic [FID_W-1:0] fid
);
    logic [KEY_W-1:0] ent_value;
    logic [KEY_W-1:0] ent_mask;
    logic [FID_W-1:0] ent_fid;
    logic             ent_live;

    // Storage: clear on reset, load on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_value <= '0;
            ent_mask  <= '0;
            ent_fid   <= '0;
            ent_live  <= 1'b0;
        end else if (wr_en) begin
            ent_value <= wr_value;
            ent_mask  <= wr_mask;
            ent_fid   <= wr_fid;
            ent_live  <= wr_live;
        end
    end

    // Compare: masked equality gated by the enable bit.
    always_comb begin
        hit = ent_live && (((key ^ ent_value) & ent_mask) == '0);
        fid = ent_fid;
    end

    // R6: a write lands its flow id and enable on the next cycle
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (fid == $past(wr_fid)));

    // R1: a write with enable 0 leaves an entry that cannot hit
    a_r1_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_live) |=> !hit);
endmodule

// File: rtl/fc_prio_pick.sv
// Module: lowest-index priority selection of a flow identifier.
// What it does: given per-entry hits and flow ids, returns a one-hot grant,
// the granted flow id (0 if none) and a none flag.
// Assumes: flow ids are packed entry 0 in the least significant slot.
module fc_prio_pick #(
    parameter int N     = fc_pkg::FC_ENTRIES,
    parameter int FID_W = fc_pkg::FC_FID_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       hits,
    input  logic [N*FID_W-1:0] fids,
    output logic [N-1:0]       grant,
    output logic [FID_W-1:0]   fid,
    output logic               none
);
    // Selection: scan from the top so the lowest hit is applied last.
    always_comb begin
        grant = '0;
        fid   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                fid      = fids[i*FID_W +: FID_W];
            end
        end
        none = ~|hits;
    end

    // R2: at most one entry is granted
    a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2: no hit exists below the granted entry
    a_r2_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> ((hits & (grant - 1'b1)) == '0));

    // R2: a grant exists whenever any entry hits
    a_r2_grant_when_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (hits != '0) |-> ((grant & hits) != '0));
endmodule

// File: rtl/fc_hash_fold.sv
// Module: XOR fold of the key into a short hash.
// What it does: zero-pads the key to a whole number of slices and XORs them.
// Assumes: purely combinational; the caller registers the result.
module fc_hash_fold #(
    parameter int KEY_W  = fc_pkg::FC_KEY_W,
    parameter int HASH_W = fc_pkg::FC_HASH_W
) (
    input  logic [KEY_W-1:0]  key,
    output logic [HASH_W-1:0] hash
);
    localparam int SLICES = fc_pkg::fc_slices(KEY_W, HASH_W);
    localparam int PAD_W  = SLICES * HASH_W;

    logic [PAD_W-1:0] padded;

    // Fold: pad, then XOR every slice together.
    always_comb begin
        padded             = '0;
        padded[KEY_W-1:0]  = key;
        hash               = '0;
        for (int s = 0; s < SLICES; s++) begin
            hash = hash ^ padded[s*HASH_W +: HASH_W];
        end
    end
endmodule

// File: rtl/fc_prog_seq.sv
// Module: range programming sequencer and transmit-enable register.
// What it does: a command loads base, count and transmit enable; each later
// data beat strobes one entry and advances the pointer.
// Assumes: a command in the same cycle as a beat wins and the beat is lost;
// the pointer never wraps past the last entry.
module fc_prog_seq #(
    parameter int N     = fc_pkg::FC_ENTRIES,
    parameter int IDX_W = $clog2(N),
    parameter int CNT_W = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [IDX_W-1:0] cmd_base,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic             cmd_tx_en,
    input  logic             wr_valid,
    output logic [N-1:0]     wr_strobe,
    output logic             tx_enable
);
    localparam int PTR_W = ((IDX_W > CNT_W) ? IDX_W : CNT_W) + 1;

    logic [PTR_W-1:0] ptr;
    logic [CNT_W-1:0] remain;
    logic             beat_ok;

    // Beat acceptance: budget left, no competing command.
    always_comb begin
        beat_ok   = wr_valid && !cmd_valid && (remain != '0);
        wr_strobe = '0;
        if (beat_ok && (ptr < PTR_W'(N))) begin
            wr_strobe[ptr[IDX_W-1:0]] = 1'b1;
        end
    end

    // Sequencer state and transmit-enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr       <= '0;
            remain    <= '0;
            tx_enable <= 1'b0;
        end else if (cmd_valid) begin
            ptr       <= PTR_W'(cmd_base);
            remain    <= cmd_count;
            tx_enable <= cmd_tx_en;
        end else if (beat_ok) begin
            ptr    <= ptr + 1'b1;
            remain <= remain - 1'b1;
        end
    end

    // R8: transmit enable only changes after a command
    a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(tx_enable));

    // R8: transmit enable follows the command bit
    a_r8_tx_load: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (tx_enable == $past(cmd_tx_en)));

    // R7: at most one entry written per cycle
    a_r7_one_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_strobe));

    // R6: each accepted beat consumes one unit of budget
    a_r6_budget_step: assert property (@(posedge clk) disable iff (!rst_n)
        beat_ok |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/flow_classifier.sv
// Module: top of the multi-entry ternary flow classifier.
// What it does: parallel masked compare against N entries, lowest-index
// priority flow id, XOR-fold hash, one register stage to the outputs, and
// a range programming port with a transmit-enable register.
// Assumes: the key is already extracted; results appear one clock after
// key_valid, aligned with the registered start-of-packet flag.
module flow_classifier #(
    parameter int KEY_W  = fc_pkg::FC_KEY_W,
    parameter int FID_W  = fc_pkg::FC_FID_W,
    parameter int HASH_W = fc_pkg::FC_HASH_W,
    parameter int N      = fc_pkg::FC_ENTRIES,
    parameter int IDX_W  = $clog2(N),
    parameter int CNT_W  = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic              key_sop,
    input  logic [KEY_W-1:0]  key_data,
    input  logic              cmd_valid,
    input  logic [IDX_W-1:0]  cmd_base,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              cmd_tx_en,
    input  logic              wr_valid,
    input  logic [KEY_W-1:0]  wr_value,
    input  logic [KEY_W-1:0]  wr_mask,
    input  logic [FID_W-1:0]  wr_flow_id,
    input  logic              wr_enable,
    output logic              res_valid,
    output logic              res_sop,
    output logic [N-1:0]      res_match,
    output logic              res_no_match,
    output logic [FID_W-1:0]  res_flow_id,
    output logic [HASH_W-1:0] res_hash,
    output logic              tx_enable
);
    logic [N-1:0]       hits;
    logic [N-1:0]       grant;
    logic [N*FID_W-1:0] fid_flat;
    logic [N-1:0]       wr_strobe;
    logic [FID_W-1:0]   pick_fid;
    logic               pick_none;
    logic [HASH_W-1:0]  key_hash;

    fc_prog_seq #(.N(N), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_base  (cmd_base),
        .cmd_count (cmd_count),
        .cmd_tx_en (cmd_tx_en),
        .wr_valid  (wr_valid),
        .wr_strobe (wr_strobe),
        .tx_enable (tx_enable)
    );

    for (genvar e = 0; e < N; e++) begin : g_entry
        fc_cam_entry #(.KEY_W(KEY_W), .FID_W(FID_W)) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_strobe[e]),
            .wr_value (wr_value),
            .wr_mask  (wr_mask),
            .wr_fid   (wr_flow_id),
            .wr_live  (wr_enable),
            .key      (key_data),
            .hit      (hits[e]),
            .fid      (fid_flat[e*FID_W +: FID_W])
        );
    end

    fc_prio_pick #(.N(N), .FID_W(FID_W)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .hits  (hits),
        .fids  (fid_flat),
        .grant (grant),
        .fid   (pick_fid),
        .none  (pick_none)
    );

    fc_hash_fold #(.KEY_W(KEY_W), .HASH_W(HASH_W)) u_hash (
        .key  (key_data),
        .hash (key_hash)
    );

    // Result stage: capture the lookup one clock after key_valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_sop      <= 1'b0;
            res_match    <= '0;
            res_no_match <= 1'b0;
            res_flow_id  <= '0;
            res_hash     <= '0;
        end else begin
            res_valid    <= key_valid;
            res_sop      <= key_valid && key_sop;
            res_match    <= hits;
            res_no_match <= pick_none;
            res_flow_id  <= pick_fid;
            res_hash     <= key_hash;
        end
    end

    // R5: a lookup yields a result exactly one cycle later
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> (res_valid && (res_sop == $past(key_sop))));

    // R5: no result without a lookup
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |=> !res_valid);

    // R3: a missed lookup reports a zero flow id and empty vector
    a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_no_match) |-> ((res_flow_id == '0) && (res_match == '0)));

    // R2: a hit result is never flagged as a miss
    a_r2_hit_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_match != '0)) |-> !res_no_match);
endmodule

// File: tb/flow_classifier_bench.sv
`timescale 1ns/1ps
module flow_classifier_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         key_valid = 1'b0, key_sop = 1'b0;
    logic [111:0] key_data = '0;
    logic         cmd_valid = 1'b0, cmd_tx_en = 1'b0;
    logic [1:0]   cmd_base = '0;
    logic [2:0]   cmd_count = '0;
    logic         wr_valid = 1'b0, wr_enable = 1'b0;
    logic [111:0] wr_value = '0, wr_mask = '0;
    logic [15:0]  wr_flow_id = '0;
    logic         res_valid, res_sop, res_no_match, tx_enable;
    logic [3:0]   res_match;
    logic [15:0]  res_flow_id, res_hash;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flow_classifier u_flow_classifier (
        .clk(clk), .rst_n(rst_n),
        .key_valid(key_valid), .key_sop(key_sop), .key_data(key_data),
        .cmd_valid(cmd_valid), .cmd_base(cmd_base), .cmd_count(cmd_count),
        .cmd_tx_en(cmd_tx_en),
        .wr_valid(wr_valid), .wr_value(wr_value), .wr_mask(wr_mask),
        .wr_flow_id(wr_flow_id), .wr_enable(wr_enable),
        .res_valid(res_valid), .res_sop(res_sop), .res_match(res_match),
        .res_no_match(res_no_match), .res_flow_id(res_flow_id),
        .res_hash(res_hash), .tx_enable(tx_enable)
    );

    // Field layout: src[111:80] dst[79:48] sport[47:32] dport[31:16] proto[15:8]
    localparam logic [111:0] M_SRC   = {32'hFFFFFFFF, 80'h0};
    localparam logic [111:0] M_DST   = {32'h0, 32'hFFFFFFFF, 48'h0};
    localparam logic [111:0] M_PROTO = {96'h0, 8'hFF, 8'h00};
    localparam logic [111:0] V_SRC   = {32'hC0A81E0D, 80'h0};
    localparam logic [111:0] V_DST   = {32'h0, 32'h0A000001, 48'h0};
    localparam logic [111:0] V_PROTO = {96'h0, 8'h11, 8'h00};

    localparam logic [111:0] K1 = {32'hC0A81E0D, 32'h0B0B0B0B, 16'h1234, 16'h0320, 8'h06, 8'h00};
    localparam logic [111:0] K5 = {32'hAC100005, 32'h0A000001, 16'h4321, 16'h0050, 8'h11, 8'h00};
    localparam logic [111:0] K6 = {32'hAC100005, 32'h0B0B0B0B, 16'hBEEF, 16'h0035, 8'h06, 8'h00};

    localparam int NV = 7;
    localparam logic [111:0] T_KEY [NV] = '{
        K1,
        {32'hAC100005, 32'h0A000001, 16'h1111, 16'h2222, 8'h06, 8'h00},
        {32'hAC100005, 32'h0B0B0B0B, 16'h7777, 16'h0001, 8'h11, 8'h00},
        {32'hC0A81E0D, 32'h0A000001, 16'hABCD, 16'hEF01, 8'h11, 8'h00},
        K5,
        K6,
        {32'hC0A81E0C, 32'h0B0B0B0B, 16'h1234, 16'h0320, 8'h06, 8'h00}
    };
    localparam logic [3:0]  T_VEC [NV] = '{4'b0001, 4'b0010, 4'b0100, 4'b0111, 4'b0110, 4'b0000, 4'b0000};
    localparam logic [15:0] T_FID [NV] = '{16'h0101, 16'h0202, 16'h0303, 16'h0101, 16'h0202, 16'h0000, 16'h0000};

    function automatic logic [15:0] fold16(input logic [111:0] k);
        logic [15:0] r = '0;
        for (int s = 0; s < 7; s++) r = r ^ k[s*16 +: 16];
        return r;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic lookup(input logic [111:0] k, input logic sop);
        @(negedge clk);
        key_valid = 1'b1; key_sop = sop; key_data = k;
        @(negedge clk);
        key_valid = 1'b0; key_sop = 1'b0;
    endtask

    task automatic send_cmd(input logic [1:0] b, input logic [2:0] c, input logic tx);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_base = b; cmd_count = c; cmd_tx_en = tx;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_beat(input logic [111:0] v, input logic [111:0] m,
                             input logic [15:0] f, input logic live);
        @(negedge clk);
        wr_valid = 1'b1; wr_value = v; wr_mask = m; wr_flow_id = f; wr_enable = live;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [3:0] vec, input logic [15:0] fid);
        chk(req, "res_match", 32'(res_match), 32'(vec));
        chk(req, "res_flow_id", 32'(res_flow_id), 32'(fid));
        chk(req, "res_no_match", 32'(res_no_match), 32'(vec == 4'b0000));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "res_valid in reset", 32'(res_valid), 32'd0);
        chk("R9", "tx_enable in reset", 32'(tx_enable), 32'd0);
        rst_n = 1'b1;
        lookup(K1, 1'b1);
        chk("R9", "res_valid", 32'(res_valid), 32'd1);
        expect_hit("R9", 4'b0000, 16'h0000);

        // R8 and R6: program entries 0..2, transmit on
        send_cmd(2'd0, 3'd3, 1'b1);
        chk("R8", "tx_enable after cmd", 32'(tx_enable), 32'd1);
        send_beat(V_SRC,   M_SRC,   16'h0101, 1'b1);
        send_beat(V_DST,   M_DST,   16'h0202, 1'b1);
        send_beat(V_PROTO, M_PROTO, 16'h0303, 1'b1);

        // R1 R2 R3 R4 R5: vector table
        for (int i = 0; i < NV; i++) begin
            lookup(T_KEY[i], (i % 2) == 0);
            chk("R5", "res_valid", 32'(res_valid), 32'd1);
            chk("R5", "res_sop", 32'(res_sop), 32'((i % 2) == 0));
            expect_hit(i == NV - 1 ? "R1" : "R2", T_VEC[i], T_FID[i]);
            chk("R4", "res_hash", 32'(res_hash), 32'(fold16(T_KEY[i])));
        end
        @(negedge clk);
        chk("R5", "res_valid idle", 32'(res_valid), 32'd0);

        // R6: wildcard into entry 3
        send_cmd(2'd3, 3'd1, 1'b1);
        send_beat('0, '0, 16'h0404, 1'b1);
        lookup(K6, 1'b1);
        expect_hit("R6", 4'b1000, 16'h0404);

        // R6 and R7: rewrite 1..2, then a surplus beat
        send_cmd(2'd1, 3'd2, 1'b1);
        send_beat(V_DST, M_DST, 16'h0AAA, 1'b1);
        send_beat(V_PROTO, M_PROTO, 16'h0333, 1'b0);
        send_beat('0, '0, 16'hBEEF, 1'b1);
        lookup(K5, 1'b1);
        expect_hit("R6", 4'b1010, 16'h0AAA);
        lookup(K6, 1'b1);
        expect_hit("R7", 4'b1000, 16'h0404);

        // R7 and R8: range past the last entry does not wrap; transmit off
        send_cmd(2'd3, 3'd2, 1'b0);
        chk("R8", "tx_enable cleared", 32'(tx_enable), 32'd0);
        send_beat('0, '0, 16'h0444, 1'b0);
        send_beat('0, '0, 16'hDEAD, 1'b0);
        lookup(K1, 1'b1);
        expect_hit("R7", 4'b0001, 16'h0101);
        lookup(K6, 1'b1);
        expect_hit("R6", 4'b0000, 16'h0000);

        // R7: zero count
        send_cmd(2'd0, 3'd0, 1'b0);
        send_beat('0, '0, 16'h0F0F, 1'b0);
        lookup(K1, 1'b1);
        expect_hit("R7", 4'b0001, 16'h0101);

        // R7: command and beat in the same cycle
        @(negedge clk);
        cmd_valid = 1'b1; cmd_base = 2'd0; cmd_count = 3'd1; cmd_tx_en = 1'b0;
        wr_valid = 1'b1; wr_value = '0; wr_mask = '0; wr_flow_id = 16'h0E0E; wr_enable = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0; wr_valid = 1'b0;
        lookup(K1, 1'b1);
        expect_hit("R7", 4'b0001, 16'h0101);

        // R8: held without commands
        repeat (5) @(negedge clk);
        chk("R8", "tx_enable held", 32'(tx_enable), 32'd0);
        send_cmd(2'd0, 3'd0, 1'b1);
        repeat (3) @(negedge clk);
        chk("R8", "tx_enable set and held", 32'(tx_enable), 32'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule